// File: doc/BRIEF.md
# SD Command CRC7 Generator (bit-serial)

This block computes the 7-bit checksum that guards an SD card command. The command is the 40 bits that precede the checksum: start bit, transmission bit, command index and 32-bit argument. The caller presents that 40-bit word in parallel and pulses a load strobe. The block then feeds the word into a 7-bit linear feedback register, one bit per clock and most significant bit first. When the last bit has been consumed it raises a valid flag.

The result and the valid flag stay unchanged for as long as the caller needs them. They are dropped only when load is asserted again. A load that arrives while a word is still being shifted abandons that word and starts over with the new one. The caller appends the end bit and drives the bus.

Top module: `sdcmd_crc7_gen`

## Requirements
- R1: While reset is asserted and after it is released with no load, `crc_o` is 0 and `valid_o` is 0.
- R2: The word 0x4000000000 (command 0, zero argument) produces a result of 0x4A.
- R3: The result equals the remainder of the generator x^7 + x^3 + 1 (mask 0x09). The register starts at zero and bits are taken from bit 39 down to bit 0. Each step forms feedback = data bit XOR register bit 6, shifts the register left and XORs the feedback into bits 0 and 3.
- R4: `valid_o` is low in the cycle after a load edge. It rises exactly 40 clock edges after the last edge at which load was sampled high.
- R5: While `valid_o` is high and load stays low, `crc_o` and `valid_o` hold their values for any number of cycles.
- R6: A load after a finished computation discards the held result. `valid_o` falls in the next cycle and the new word's result appears 40 edges later.
- R7: A load during a computation restarts it with the new word. The timing of R4 counts from the new load, and the result is that of the new word alone.
- R8: Boundary words: all zeros gives 0x00. All ones, alternating patterns and single set bits at positions 39 and 0 each give the value predicted by R3.
- R9: While load is held high on consecutive edges, `valid_o` stays low. The word sampled at the last such edge is the one computed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Starts a computation with `word_i` |
| word_i | input | 40 | Command word, bit 39 sent first |
| crc_o | output | 7 | Checksum; meaningful while `valid_o` is high |
| valid_o | output | 1 | High once all bits are consumed, held until next load |

## Verification
The bench builds the block with its default parameters: a 40-bit word, a 7-bit register and generator mask 0x09. These are the only values the SD command format uses, so the known command checksums can be compared directly. With a 40-cycle computation, a full run of valid timing can be measured edge by edge. That leaves room for restarts at mid-word, long hold periods and a strobe held across many edges.

// File: rtl/sdcrc_pkg.sv
package sdcrc_pkg;

    localparam int unsigned DEF_WORD_W = 40;
    localparam int unsigned DEF_CRC_W  = 7;
    localparam logic [6:0]  DEF_POLY   = 7'h09;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_t;

endpackage

// File: rtl/sdcrc_seq.sv
module sdcrc_seq
    import sdcrc_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic load_i,
    output logic step_o,
    output logic done_o
);

    localparam int unsigned CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    typedef struct packed {
        phase_t           phase;
        logic [CNT_W-1:0] cnt;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.phase = PH_RUN;
            st_d.cnt   = '0;
        end else begin
            unique case (st_q.phase)
                PH_RUN: begin
                    if (st_q.cnt == LAST_IDX) begin
                        st_d.phase = PH_DONE;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.phase <= PH_IDLE;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign step_o = (st_q.phase == PH_RUN) && !load_i;
    assign done_o = (st_q.phase == PH_DONE);

    // R4: a load edge always clears the finished flag in the next cycle
    a_r4_clear_after_load: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> !done_o);

    // R5: once finished, the flag stays up until a load
    a_r5_done_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && !load_i) |=> done_o);

    // R4: the counter never runs past the last bit index
    a_r4_cnt_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.cnt <= LAST_IDX);

endmodule

// File: rtl/sdcrc_shifter.sv
module sdcrc_shifter
    import sdcrc_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              bit_o
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
    } sh_state_t;

    sh_state_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d.word = word_i;
        end else if (step_i) begin
            sh_d.word = {sh_q.word[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sh_q.word <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign bit_o = sh_q.word[WORD_W-1];

    // R3: bits are presented most significant first, one per step
    a_r3_msb_order: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && !load_i) |=> (bit_o == $past(sh_q.word[WORD_W-2])));

endmodule

// File: rtl/sdcrc_lfsr.sv
module sdcrc_lfsr
    import sdcrc_pkg::*;
#(
    parameter int unsigned CRC_W = DEF_CRC_W,
    parameter logic [CRC_W-1:0] POLY = DEF_POLY
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic             bit_i,
    output logic [CRC_W-1:0] crc_o
);

    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } lf_state_t;

    lf_state_t  lf_d, lf_q;
    logic       fb;
    logic [CRC_W-1:0] stepped;

    assign fb = bit_i ^ lf_q.crc[CRC_W-1];

    for (genvar i = 0; i < CRC_W; i++) begin : g_tap
        if (i == 0) begin : g_lo
            assign stepped[i] = POLY[i] & fb;
        end else begin : g_hi
            assign stepped[i] = lf_q.crc[i-1] ^ (POLY[i] & fb);
        end
    end

    always_comb begin
        lf_d = lf_q;
        if (clear_i) begin
            lf_d.crc = '0;
        end else if (step_i) begin
            lf_d.crc = stepped;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lf_q.crc <= '0;
        end else begin
            lf_q <= lf_d;
        end
    end

    assign crc_o = lf_q.crc;

    // R6: a load throws away the previous register contents
    a_r6_clear_on_load: assert property (@(posedge clk_i) disable iff (rst_i)
        clear_i |=> (crc_o == '0));

    // R5: without a step or clear the register does not move
    a_r5_hold_value: assert property (@(posedge clk_i) disable iff (rst_i)
        (!clear_i && !step_i) |=> $stable(crc_o));

endmodule

// File: rtl/sdcmd_crc7_gen.sv
module sdcmd_crc7_gen
    import sdcrc_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned CRC_W  = DEF_CRC_W,
    parameter logic [CRC_W-1:0] POLY = DEF_POLY
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [CRC_W-1:0]  crc_o,
    output logic              valid_o
);

    localparam int unsigned CHK_W = $clog2(WORD_W + 2);

    logic step;
    logic data_bit;

    sdcrc_seq #(
        .WORD_W (WORD_W)
    ) seq_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (load_i),
        .step_o (step),
        .done_o (valid_o)
    );

    sdcrc_shifter #(
        .WORD_W (WORD_W)
    ) shifter_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (load_i),
        .step_i (step),
        .word_i (word_i),
        .bit_o  (data_bit)
    );

    sdcrc_lfsr #(
        .CRC_W (CRC_W),
        .POLY  (POLY)
    ) lfsr_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (load_i),
        .step_i  (step),
        .bit_i   (data_bit),
        .crc_o   (crc_o)
    );

    // Independent edge counter used only by the timing assertions below
    logic [CHK_W-1:0] chk_cnt_q;
    logic             chk_run_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chk_cnt_q <= '0;
            chk_run_q <= 1'b0;
        end else if (load_i) begin
            chk_cnt_q <= '0;
            chk_run_q <= 1'b1;
        end else if (chk_run_q) begin
            chk_cnt_q <= chk_cnt_q + 1'b1;
            if (chk_cnt_q == CHK_W'(WORD_W - 1)) begin
                chk_run_q <= 1'b0;
            end
        end
    end

    // R4: result not flagged while bits remain to be consumed
    a_r4_low_while_counting: assert property (@(posedge clk_i) disable iff (rst_i)
        chk_run_q |-> !valid_o);

    // R4: flag rises on exactly the last shift edge after the load
    a_r4_rise_on_last: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(valid_o) |-> ($past(chk_run_q) && ($past(chk_cnt_q) == CHK_W'(WORD_W - 1))));

    // R5: the flagged result is stable until the next load
    a_r5_result_held: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_o && !load_i) |=> (valid_o && $stable(crc_o)));

    // R1: nothing is flagged directly out of reset
    a_r1_quiet_after_reset: assert property (@(posedge clk_i)
        $past(rst_i) |-> (!valid_o && crc_o == '0));

endmodule

// File: tb/sdcmd_crc7_gen_tb.sv
module sdcmd_crc7_gen_tb_top;

    localparam int unsigned WW = 40;
    localparam int unsigned CW = 7;

    logic          clk = 1'b0;
    logic          rst;
    logic          load;
    logic [WW-1:0] word;
    logic [CW-1:0] crc;
    logic          valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sdcmd_crc7_gen dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .load_i  (load),
        .word_i  (word),
        .crc_o   (crc),
        .valid_o (valid)
    );

    function automatic logic [CW-1:0] model(input logic [WW-1:0] w);
        logic [CW-1:0] r = '0;
        for (int i = WW - 1; i >= 0; i--) begin
            logic fb = w[i] ^ r[CW-1];
            r = {r[CW-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Load a word (load held for 'hold' edges), check timing and result.
    task automatic run_word(input logic [WW-1:0] w, input int hold,
                            input logic [CW-1:0] exp, input string req);
        bit early = 1'b0;
        @(negedge clk);
        load = 1'b1;
        word = w;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            if (valid) early = 1'b1;
        end
        load = 1'b0;
        word = '0;
        check(!early, {req, " valid low while loading"}, valid, 0);
        for (int j = 1; j < WW; j++) begin
            @(negedge clk);
            if (valid) early = 1'b1;
        end
        check(!early, {req, " R4 valid low before last shift"}, 1, 0);
        @(negedge clk);
        check(valid == 1'b1, {req, " R4 valid after 40 edges"}, valid, 1);
        check(crc == exp, {req, " result"}, crc, exp);
    endtask

    task automatic t_reset();
        rst = 1'b1; load = 1'b0; word = '0;
        repeat (3) @(negedge clk);
        check(crc == 0 && valid == 0, "R1 during reset", {crc, valid}, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check(crc == 0 && valid == 0, "R1 after reset", {crc, valid}, 0);
    endtask

    task automatic t_cmd0();
        run_word(40'h40_0000_0000, 1, 7'h4A, "R2 cmd0");
    endtask

    task automatic t_known();
        run_word(40'h48_0000_01AA, 1, 7'h43, "R3 cmd8");
        run_word(40'h77_0000_0000, 1, model(40'h77_0000_0000), "R3 cmd55");
        run_word(40'h69_4000_0000, 1, model(40'h69_4000_0000), "R3 acmd41");
    endtask

    task automatic t_bounds();
        run_word('0, 1, 7'h00, "R8 zeros");
        run_word('1, 1, model('1), "R8 ones");
        run_word(40'hAA_AAAA_AAAA, 1, model(40'hAA_AAAA_AAAA), "R8 alt");
        run_word(40'h80_0000_0000, 1, model(40'h80_0000_0000), "R8 msb");
        run_word(40'h00_0000_0001, 1, 7'h09, "R8 lsb");
    endtask

    task automatic t_hold();
        logic [CW-1:0] ref_crc;
        bit moved = 1'b0;
        run_word(40'h51_1234_5678, 1, model(40'h51_1234_5678), "R5 setup");
        ref_crc = crc;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (!valid || crc != ref_crc) moved = 1'b1;
        end
        check(!moved, "R5 held 300 cycles", crc, ref_crc);
    endtask

    task automatic t_reload();
        @(negedge clk);
        load = 1'b1; word = 40'h4C_0000_0000;
        @(negedge clk);
        load = 1'b0;
        check(valid == 1'b0, "R6 valid drops after reload", valid, 0);
        for (int j = 1; j < WW; j++) @(negedge clk);
        check(valid == 1'b0, "R6 still busy at 39", valid, 0);
        @(negedge clk);
        check(valid && crc == model(40'h4C_0000_0000), "R6 new result", crc,
              model(40'h4C_0000_0000));
    endtask

    task automatic t_restart();
        @(negedge clk);
        load = 1'b1; word = 40'h7F_FFFF_FFFF;
        @(negedge clk);
        load = 1'b0;
        repeat (17) @(negedge clk);
        check(valid == 1'b0, "R7 busy midway", valid, 0);
        run_word(40'h52_0000_0A0B, 1, model(40'h52_0000_0A0B), "R7 restart");
    endtask

    task automatic t_held_load();
        run_word(40'h63_DEAD_BEEF, 60, model(40'h63_DEAD_BEEF), "R9 held load");
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_cmd0();
        t_known();
        t_bounds();
        t_hold();
        t_reload();
        t_restart();
        t_held_load();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule